// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters and a global history register. The history records the outcomes of recent conditional branches. A fetch stage presents a branch address on the lookup port and receives a taken/not-taken guess in the same cycle. The table is indexed by a hash of the address and the history.

Once the real outcome of a branch is known, the outcome is presented on the update port. The block then trains the selected counter and shifts the outcome into the history. Training always uses the true outcome, so no checkpoint or history repair is ever required. Only conditional branches should be presented on either port. Other branch kinds are simply not presented, and so leave the state untouched.

A build-time parameter chooses the index hash:
- XOR of address and history (the default).
- History bits placed above address bits. The history is then half the index width, so the table size is the same in both modes.

Two running totals, updates seen and mispredictions, are provided so that prediction accuracy can be measured.

Top module: `gshare_predictor`

## Requirements
- R1: After synchronous reset, every counter holds 2'b10 (weakly taken), the history is all zeros, and both totals read zero; any lookup directly after reset predicts taken.
- R2: `lk_taken` is the most significant bit of the selected counter, valid combinationally in the cycle `lk_valid` is high; with `lk_valid` low it is 0.
- R3: On an update the selected counter moves up by one for taken and down by one for not-taken, saturating at 2'b11 and 2'b00.
- R4: On each update the history shifts left by one with the actual outcome (1 = taken) entering bit 0.
- R5: With `HASH_MODE` = 0 the index is `pc[IDX_W-1:0] XOR history`, history being `IDX_W` bits wide.
- R6: With `HASH_MODE` = 1 the index is `{history[IDX_W/2-1:0], pc[IDX_W-IDX_W/2-1:0]}`, history being `IDX_W/2` bits wide.
- R7: A lookup and an update in the same cycle on the same index return the counter value from before that update.
- R8: While `upd_valid` is low, no counter, no history bit and no total changes, whatever `upd_pc` and `upd_taken` carry.
- R9: Each update adds one to `stat_updates`; it adds one to `stat_misses` when the MSB of the selected counter before the update differs from the actual outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved conditional branch present |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| stat_updates | output | CNT_W | Number of updates since reset |
| stat_misses | output | CNT_W | Number of mispredicted updates since reset |

## Verification
The main stimulus is a stream of branches. It includes a loop branch with a taken-taken-taken-exit pattern, a strictly alternating branch and an always-not-taken branch. It also includes addresses that agree in their low bits but differ above them.

The stream runs into an XOR-hashed instance and a concatenation-hashed instance at the same time. Their predictions split whenever the two hashes send the same history to different counters. This makes the index formula itself visible at the prediction output.

Long taken runs followed by a single exit tell saturation apart from plain wrapping. Idle cycles with garbage on the update port, and a reset after training, show that state is kept or cleared at the right moments.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_TAKEN = 2'b10;
  localparam ctr_t CTR_MAX        = 2'b11;
  localparam ctr_t CTR_MIN        = 2'b00;

  // saturating step of a 2-bit counter
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  // history width implied by the hash choice
  function automatic int hist_width(input int idx_w, input int mode);
    return (mode == 0) ? idx_w : idx_w / 2;
  endfunction

endpackage

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int PC_W      = 16,
  parameter int IDX_W     = 8,
  parameter int HIST_W    = 8,
  parameter int HASH_MODE = 0
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] ghr,
  output logic [IDX_W-1:0]  idx
);

  localparam int PC_KEEP = IDX_W - HIST_W;

  generate
    if (HASH_MODE == 0) begin : g_xor
      assign idx = pc[IDX_W-1:0] ^ ghr;
    end else begin : g_cat
      assign idx = {ghr, pc[PC_KEEP-1:0]};
    end
  endgenerate

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic [IDX_W-1:0] wr_idx,
  output ctr_t             wr_old,
  input  logic             wr_en,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];

  // both reads see the table as it stood before this edge
  assign rd_ctr = tbl[rd_idx];
  assign wr_old = tbl[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WEAK_TAKEN;
    end else if (wr_en) begin
      tbl[wr_idx] <= ctr_step(wr_old, wr_taken);
    end
  end

endmodule

// File: rtl/gshare_history.sv
module gshare_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] ghr
);

  logic [HIST_W-1:0] ghr_nxt;

  generate
    if (HIST_W == 1) begin : g_one
      assign ghr_nxt = outcome;
    end else begin : g_many
      assign ghr_nxt = {ghr[HIST_W-2:0], outcome};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           ghr <= '0;
    else if (shift_en) ghr <= ghr_nxt;
  end

endmodule

// File: rtl/gshare_stats.sv
module gshare_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             miss,
  output logic [CNT_W-1:0] n_upd,
  output logic [CNT_W-1:0] n_miss
);

  always_ff @(posedge clk) begin
    if (rst) begin
      n_upd  <= '0;
      n_miss <= '0;
    end else if (upd) begin
      n_upd <= n_upd + 1'b1;
      if (miss) n_miss <= n_miss + 1'b1;
    end
  end

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int IDX_W     = 8,
  parameter int HASH_MODE = 0,
  parameter int CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_taken,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  output logic [CNT_W-1:0] stat_updates,
  output logic [CNT_W-1:0] stat_misses
);

  localparam int HIST_W = hist_width(IDX_W, HASH_MODE);

  logic [HIST_W-1:0] ghr_q;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  upd_idx;
  ctr_t              lk_ctr;
  ctr_t              upd_ctr;
  logic              upd_miss;

  gshare_index #(
    .PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .HASH_MODE(HASH_MODE)
  ) i_lk_hash (
    .pc(lk_pc), .ghr(ghr_q), .idx(lk_idx)
  );

  gshare_index #(
    .PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .HASH_MODE(HASH_MODE)
  ) i_upd_hash (
    .pc(upd_pc), .ghr(ghr_q), .idx(upd_idx)
  );

  gshare_pht #(.IDX_W(IDX_W)) i_pht (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_ctr(lk_ctr),
    .wr_idx(upd_idx), .wr_old(upd_ctr),
    .wr_en(upd_valid), .wr_taken(upd_taken)
  );

  gshare_history #(.HIST_W(HIST_W)) i_hist (
    .clk(clk), .rst(rst),
    .shift_en(upd_valid), .outcome(upd_taken), .ghr(ghr_q)
  );

  assign upd_miss = upd_ctr[1] ^ upd_taken;

  gshare_stats #(.CNT_W(CNT_W)) i_stats (
    .clk(clk), .rst(rst),
    .upd(upd_valid), .miss(upd_miss),
    .n_upd(stat_updates), .n_miss(stat_misses)
  );

  assign lk_taken = lk_valid & lk_ctr[1];

endmodule

// File: rtl/gshare_checker.sv
module gshare_checker #(
  parameter int HIST_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              lk_taken,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] ghr,
  input logic [CNT_W-1:0]  stat_updates,
  input logic [CNT_W-1:0]  stat_misses
);

  // R1: state cleared in the first cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ghr == '0 && stat_updates == '0 && stat_misses == '0));

  // R2: no lookup, no taken guess
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !lk_taken);

  // R4: newest outcome lands in bit 0
  p_hist_new_r4: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ghr[0] == $past(upd_taken));

  // R8: idle update port leaves state alone
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> ($stable(ghr) && $stable(stat_updates) && $stable(stat_misses)));

  // R9: one count per update
  p_count_r9: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> stat_updates == $past(stat_updates) + 1'b1);

  // R9: misses never exceed updates
  p_miss_bound_r9: assert property (@(posedge clk) disable iff (rst)
    stat_misses <= stat_updates);

endmodule

bind gshare_predictor gshare_checker #(.HIST_W(HIST_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_taken(lk_taken),
  .upd_valid(upd_valid), .upd_taken(upd_taken), .ghr(ghr_q),
  .stat_updates(stat_updates), .stat_misses(stat_misses)
);

// File: tb/test_gshare_predictor.sv
`timescale 1ns/1ps
module test_gshare_predictor;

  localparam int PC_W  = 16;
  localparam int IDX_W = 8;
  localparam int CNT_W = 32;
  localparam int NVEC  = 32;

  // {pc, taken}
  localparam logic [16:0] VEC [NVEC] = '{
    {16'h0040,1'b1},{16'h0040,1'b1},{16'h0040,1'b1},{16'h0040,1'b0},
    {16'h0013,1'b0},{16'h0013,1'b1},{16'h0013,1'b0},{16'h0013,1'b1},
    {16'h00F0,1'b0},{16'h00F0,1'b0},{16'h00F0,1'b0},{16'h00F0,1'b0},
    {16'h1240,1'b1},{16'h2240,1'b0},{16'h1240,1'b1},{16'h2240,1'b0},
    {16'h0000,1'b1},{16'h0000,1'b1},{16'h0000,1'b1},{16'h0000,1'b1},
    {16'h0000,1'b1},{16'h0000,1'b1},{16'h0000,1'b1},{16'h0000,1'b1},
    {16'h0000,1'b1},{16'h0000,1'b1},{16'h0000,1'b1},{16'h0000,1'b0},
    {16'h0000,1'b1},{16'h0040,1'b1},{16'h0040,1'b0},{16'h00F0,1'b0}
  };

  logic clk = 0;
  logic rst = 1;
  logic lk_valid = 0;
  logic [PC_W-1:0] lk_pc = '0;
  logic upd_valid = 0;
  logic [PC_W-1:0] upd_pc = '0;
  logic upd_taken = 0;
  logic x_taken, c_taken;
  logic [CNT_W-1:0] x_upd, x_miss, c_upd, c_miss;

  always #2.5 clk = ~clk;

  gshare_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HASH_MODE(0), .CNT_W(CNT_W)) i_gshare_predictor (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(x_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .stat_updates(x_upd), .stat_misses(x_miss)
  );

  gshare_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HASH_MODE(1), .CNT_W(CNT_W)) i_gshare_cat (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(c_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .stat_updates(c_upd), .stat_misses(c_miss)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state from the requirements
  int         pm [2][256];
  logic [7:0] gm [2];
  int         mu [2];
  int         mm [2];

  function automatic int midx(int m, logic [15:0] pc);
    if (m == 0) return int'(pc[7:0] ^ gm[0]);         // R5
    return int'({gm[1][3:0], pc[3:0]});               // R6
  endfunction

  function automatic logic mpred(int m, logic [15:0] pc);
    return pm[m][midx(m, pc)] >= 2;
  endfunction

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 256; i++) pm[m][i] = 2;
      gm[m] = '0; mu[m] = 0; mm[m] = 0;
    end
  endtask

  task automatic model_update(logic [15:0] pc, logic t);
    for (int m = 0; m < 2; m++) begin
      int k;
      k = midx(m, pc);
      mu[m]++;
      if ((pm[m][k] >= 2) != t) mm[m]++;
      if (t && pm[m][k] < 3) pm[m][k]++;
      if (!t && pm[m][k] > 0) pm[m][k]--;
      gm[m] = {gm[m][6:0], t};
      if (m == 1) gm[m] = gm[m] & 8'h0F;
    end
  endtask

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; lk_valid = 0; upd_valid = 0;
    @(negedge clk); @(negedge clk); rst = 0;
    model_reset();
  endtask

  // lookup and update of the same branch in one cycle
  task automatic step(logic [15:0] pc, logic t);
    @(negedge clk);
    lk_valid = 1; lk_pc = pc; upd_valid = 1; upd_pc = pc; upd_taken = t;
    #1;
    chk("R5/R7/R3/R4 xor lookup", x_taken, mpred(0, pc));
    chk("R6/R7/R3/R4 cat lookup", c_taken, mpred(1, pc));
    model_update(pc, t);
    @(posedge clk); #1;
    upd_valid = 0; lk_valid = 0;
  endtask

  task automatic stats_check(string tag);
    @(negedge clk); #1;
    chk({tag, " R9 xor updates"}, x_upd, mu[0]);
    chk({tag, " R9 xor misses"},  x_miss, mm[0]);
    chk({tag, " R9 cat updates"}, c_upd, mu[1]);
    chk({tag, " R9 cat misses"},  c_miss, mm[1]);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1: reset state
    @(negedge clk); lk_valid = 1; lk_pc = 16'hABCD; #1;
    chk("R1 xor weakly taken", x_taken, 1);
    chk("R1 cat weakly taken", c_taken, 1);
    chk("R1 xor updates zero", x_upd, 0);
    chk("R1 cat misses zero", c_miss, 0);

    // R2: no lookup gives 0
    @(negedge clk); lk_valid = 0; #1;
    chk("R2 xor idle", x_taken, 0);
    chk("R2 cat idle", c_taken, 0);

    // main vector table
    for (int v = 0; v < NVEC; v++) step(VEC[v][16:1], VEC[v][0]);
    stats_check("table");

    // R8: garbage on an idle update port
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); upd_valid = 0; upd_pc = 16'h0040 + 16'(i); upd_taken = i[0];
    end
    @(negedge clk); lk_valid = 1; lk_pc = 16'h0040; #1;
    chk("R8 xor unchanged", x_taken, mpred(0, 16'h0040));
    chk("R8 cat unchanged", c_taken, mpred(1, 16'h0040));
    lk_valid = 0;
    stats_check("R8 idle");

    // R3: drive one counter to the floor, then one taken keeps not-taken
    for (int i = 0; i < 12; i++) step(16'h0000, 1'b0);
    step(16'h0000, 1'b1);
    step(16'h0000, 1'b0);
    stats_check("R3 floor");

    // R1: reset after training restores weakly taken
    do_reset();
    @(negedge clk); lk_valid = 1; lk_pc = 16'h00F0; #1;
    chk("R1 xor after retrain", x_taken, 1);
    chk("R1 cat after retrain", c_taken, 1);
    lk_valid = 0;
    stats_check("R1 cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule